// File: doc/BRIEF.md
# Multiplierless Vector Magnitude Estimator

This block estimates the length of a complex sample from its signed in-phase and quadrature parts, without a square root and without multipliers. It takes the absolute value of each part and labels the larger one Max and the smaller one Min. It then forms a weighted sum of the two, using coefficients that are reciprocals of powers of two. Every scaling is a hardwired right shift that truncates, combined with adders and subtractors.

A three-bit mode input picks one of five coefficient sets. Three sets differ only in the Min weight. The other two scale the plain sum Max + Min/2 down by 7/8 or by 15/16. Samples enter with a valid strobe and leave after a fixed three-stage registered pipeline. The valid strobe travels alongside the data, so a caller can stream one sample per clock.

The output is one bit wider than the input, so no estimate can overflow.

Top module: `mag_est`

## Requirements
- R1: Each input is N-bit two's complement. Its absolute value is taken in N bits unsigned without wrap, so the most negative code -2^(N-1) yields 2^(N-1).
- R2: Max is |I| when |I| is strictly greater than |Q|, otherwise |Q|; Min is the other one. Swapping I and Q leaves the result unchanged.
- R3: With in_mode = 0, the result is Max + (Min >> 1).
- R4: With in_mode = 1, the result is Max + (Min >> 2).
- R5: With in_mode = 2, the result is Max + (Min >> 2) + (Min >> 3). Each shift truncates on its own.
- R6: With in_mode = 3, S = Max + (Min >> 1) and the result is S - (S >> 3).
- R7: With in_mode = 4, S = Max + (Min >> 1) and the result is S - (S >> 4). The result is never above S.
- R8: in_mode values 5, 6 and 7 give the same result as mode 0.
- R9: out_valid equals in_valid as sampled three rising edges earlier, and out_mag carries that sample's result in the same cycle.
- R10: While out_valid is low, out_mag keeps the last result delivered, or 0 if none has been delivered since reset.
- R11: A synchronous active-high rst clears all valid bits and data registers. out_valid and out_mag read 0 after the first edge with rst high.
- R12: out_mag is N+1 bits unsigned and never wraps. Full-scale inputs (-2^(N-1), -2^(N-1)) in mode 0 give 3·2^(N-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | N | In-phase part, two's complement |
| in_q | input | N | Quadrature part, two's complement |
| in_mode | input | 3 | Coefficient set select |
| out_valid | output | 1 | Result strobe, three clocks after in_valid |
| out_mag | output | N+1 | Unsigned magnitude estimate |

## Verification
Nearly every internal fault changes out_mag for some input pattern, exactly three clocks after that sample entered. A wrong absolute value, a wrong choice of Max, or a wrong shift produces a numeric error. A mode carried in the wrong stage misapplies the post-scale to the wrong sample, which shows up as a mismatch in mixed-mode streams. A broken valid chain appears as out_valid one cycle early or late, or as out_mag changing during idle cycles. Random streams with random gaps and modes are therefore combined with directed full-scale and tie cases.

// File: rtl/mag_est_pkg.sv
`timescale 1ns/1ps
package mag_est_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_HALF    = 3'd0,
      MODE_QUARTER = 3'd1,
      MODE_3_8     = 3'd2,
      MODE_7_8     = 3'd3,
      MODE_15_16   = 3'd4
   } est_mode_e;
endpackage

// File: rtl/mag_abs_stage.sv
`timescale 1ns/1ps
module mag_abs_stage
   import mag_est_pkg::*;
#(
   parameter int N = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  v_in,
   input  logic [N-1:0]          i_in,
   input  logic [N-1:0]          q_in,
   input  logic [MODE_W-1:0]     mode_in,
   output logic                  v_q,
   output logic [1:0][N-1:0]     mag_q,
   output logic [MODE_W-1:0]     mode_q
);
   logic [1:0][N-1:0] raw;
   logic [1:0][N-1:0] abs_c;

   assign raw[0] = i_in;
   assign raw[1] = q_in;

   for (genvar k = 0; k < 2; k++) begin : g_abs
      // negate in N bits: the most negative code maps to 2^(N-1) unsigned
      assign abs_c[k] = raw[k][N-1] ? (~raw[k] + 1'b1) : raw[k];

      // R1: an absolute value never exceeds 2^(N-1)
      p_abs_range_r1: assert property (@(posedge clk) disable iff (rst)
         v_in |=> (mag_q[k] <= {1'b1, {(N-1){1'b0}}}));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q    <= 1'b0;
         mag_q  <= '0;
         mode_q <= '0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            mag_q  <= abs_c;
            mode_q <= mode_in;
         end
      end
   end
endmodule

// File: rtl/mag_sum_stage.sv
`timescale 1ns/1ps
module mag_sum_stage
   import mag_est_pkg::*;
#(
   parameter int N = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  v_in,
   input  logic [1:0][N-1:0]     mag_in,
   input  logic [MODE_W-1:0]     mode_in,
   output logic                  v_q,
   output logic [N:0]            sum_q,
   output logic [MODE_W-1:0]     mode_q
);
   localparam int W = N + 1;

   logic          i_wins;
   logic [W-1:0]  big_w, small_w, term_w, sum_c;

   // strict compare: on a tie Q is taken as the larger component
   assign i_wins  = mag_in[0] > mag_in[1];
   assign big_w   = {1'b0, (i_wins ? mag_in[0] : mag_in[1])};
   assign small_w = {1'b0, (i_wins ? mag_in[1] : mag_in[0])};

   always_comb begin
      case (mode_in)
         MODE_QUARTER: term_w = small_w >> 2;
         MODE_3_8:     term_w = (small_w >> 2) + (small_w >> 3);
         default:      term_w = small_w >> 1;
      endcase
   end

   assign sum_c = big_w + term_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q    <= 1'b0;
         sum_q  <= '0;
         mode_q <= '0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            sum_q  <= sum_c;
            mode_q <= mode_in;
         end
      end
   end

   // R2: the weighted sum is never below the larger component
   p_sum_ge_max_r2: assert property (@(posedge clk) disable iff (rst)
      v_in |=> (sum_q >= {1'b0, $past((mag_in[1] < mag_in[0]) ? mag_in[0] : mag_in[1])}));

   // R12: the sum fits below 2^N
   p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
      v_in |=> (sum_q[N] == 1'b0));
endmodule

// File: rtl/mag_scale_stage.sv
`timescale 1ns/1ps
module mag_scale_stage
   import mag_est_pkg::*;
#(
   parameter int N = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  v_in,
   input  logic [N:0]            sum_in,
   input  logic [MODE_W-1:0]     mode_in,
   output logic                  v_q,
   output logic [N:0]            mag_q
);
   localparam int W = N + 1;

   logic [W-1:0] scaled_c;

   always_comb begin
      case (mode_in)
         MODE_7_8:   scaled_c = sum_in - (sum_in >> 3);
         MODE_15_16: scaled_c = sum_in - (sum_in >> 4);
         default:    scaled_c = sum_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= 1'b0;
         mag_q <= '0;
      end else begin
         v_q <= v_in;
         if (v_in) mag_q <= scaled_c;
      end
   end

   // R7: post-scaling only ever reduces the sum
   p_scale_le_sum_r7: assert property (@(posedge clk) disable iff (rst)
      v_in |=> (mag_q <= $past(sum_in)));

   // R10: the result register holds during idle cycles
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !v_in |=> $stable(mag_q));
endmodule

// File: rtl/mag_est.sv
`timescale 1ns/1ps
module mag_est
   import mag_est_pkg::*;
#(
   parameter int N = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [N-1:0]      in_i,
   input  logic [N-1:0]      in_q,
   input  logic [2:0]        in_mode,
   output logic              out_valid,
   output logic [N:0]        out_mag
);
   localparam int OW = N + 1;

   if (N < 4) begin : g_bad_width
      $error("mag_est: N must be at least 4 for the 1/16 post-scale");
   end
   if (MODE_W != 3) begin : g_bad_mode
      $error("mag_est: mode field must be three bits");
   end

   logic                  v1, v2;
   logic [1:0][N-1:0]     mag1;
   logic [MODE_W-1:0]     mode1, mode2;
   logic [OW-1:0]         sum2;

   mag_abs_stage #(.N(N)) u_abs (
      .clk(clk), .rst(rst), .v_in(in_valid), .i_in(in_i), .q_in(in_q),
      .mode_in(in_mode), .v_q(v1), .mag_q(mag1), .mode_q(mode1));

   mag_sum_stage #(.N(N)) u_sum (
      .clk(clk), .rst(rst), .v_in(v1), .mag_in(mag1), .mode_in(mode1),
      .v_q(v2), .sum_q(sum2), .mode_q(mode2));

   mag_scale_stage #(.N(N)) u_scale (
      .clk(clk), .rst(rst), .v_in(v2), .sum_in(sum2), .mode_in(mode2),
      .v_q(out_valid), .mag_q(out_mag));

   // edges since reset, saturating at 3, so $past never reaches into reset
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst) warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R9: fixed three-cycle valid latency
   p_latency_r9: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R11: reset clears the output strobe and data
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> (!out_valid && out_mag == '0));
endmodule

// File: tb/sim_mag_est.sv
`timescale 1ns/1ps
module sim_mag_est;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [N-1:0]  in_i = '0;
   logic [N-1:0]  in_q = '0;
   logic [2:0]    in_mode = '0;
   logic          out_valid;
   logic [N:0]    out_mag;

   int checks = 0;
   int failures = 0;

   logic hv [3];
   int   he [3];
   int   hr [3];
   int   last_mag;

   always #5 clk = ~clk;

   mag_est #(.N(N)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .in_mode(in_mode), .out_valid(out_valid), .out_mag(out_mag));

   function automatic int model(int iv, int qv, int m);
      int ai, aq, mx, mn, s;
      ai = (iv < 0) ? -iv : iv;
      aq = (qv < 0) ? -qv : qv;
      mx = (ai > aq) ? ai : aq;
      mn = (ai > aq) ? aq : ai;
      s  = mx + (mn >> 1);
      case (m)
         1: return mx + (mn >> 2);
         2: return mx + (mn >> 2) + (mn >> 3);
         3: return s - (s >> 3);
         4: return s - (s >> 4);
         default: return s;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int k = 0; k < 3; k++) begin
         hv[k] = 1'b0; he[k] = 0; hr[k] = 0;
      end
      last_mag = 0;
   endtask

   // one clock: check what is due now, then drive the next sample
   task automatic step(input bit v, input int iv, input int qv, input int m, input int rq);
      @(negedge clk);
      check(out_valid == hv[2], "R9 out_valid", int'(out_valid), int'(hv[2]));
      if (hv[2]) begin
         check(int'(out_mag) == he[2], $sformatf("R%0d out_mag", hr[2]), int'(out_mag), he[2]);
         last_mag = he[2];
      end else begin
         check(int'(out_mag) == last_mag, "R10 idle hold", int'(out_mag), last_mag);
      end
      hv[2] = hv[1]; he[2] = he[1]; hr[2] = hr[1];
      hv[1] = hv[0]; he[1] = he[0]; hr[1] = hr[0];
      hv[0] = v; he[0] = v ? model(iv, qv, m) : 0; hr[0] = rq;
      in_valid = v;
      in_i     = iv[N-1:0];
      in_q     = qv[N-1:0];
      in_mode  = m[2:0];
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_hist();
      repeat (2) @(negedge clk);
      // R11: reset state
      check(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
      check(out_mag == '0, "R11 reset data", int'(out_mag), 0);
      rst = 1'b0;

      step(1, -128, -128, 0, 12);  // R12 full scale: 192
      step(1, -128, 0, 4, 1);      // R1 most negative code, mode 4
      step(1, 127, -128, 0, 1);    // R1
      step(1, 5, 100, 1, 2);       // R2 Q larger
      step(1, 100, 5, 1, 2);       // R2 I larger, same result
      step(1, -60, -60, 0, 2);     // R2 tie
      step(1, 40, -90, 0, 3);      // R3
      step(1, -33, 77, 1, 4);      // R4
      step(1, 7, 100, 2, 5);       // R5 per-shift truncation: 101
      step(1, 120, -64, 2, 5);     // R5
      step(1, 100, 50, 3, 6);      // R6
      step(1, -127, 31, 3, 6);     // R6
      step(1, 100, 50, 4, 7);      // R7
      step(1, -128, -128, 4, 7);   // R7
      step(1, 90, 45, 5, 8);       // R8
      step(1, 90, 45, 6, 8);       // R8
      step(1, 90, 45, 7, 8);       // R8
      step(0, 3, 3, 3, 10);        // R10 idle gaps
      step(0, 9, 9, 1, 10);
      step(1, 1, 0, 0, 3);
      step(0, 0, 0, 0, 10);
      for (int n = 0; n < 3000; n++) begin
         int iv, qv, m;
         iv = int'($urandom % 256) - 128;
         qv = int'($urandom % 256) - 128;
         m  = int'($urandom % 8);
         step(($urandom % 4) != 0, iv, qv, m, (m > 4) ? 8 : m + 3);
      end
      repeat (4) step(0, 0, 0, 0, 10);

      // R11: reset in the middle of a stream
      step(1, 50, 60, 0, 3);
      step(1, 70, 20, 4, 7);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R11 mid-stream valid", int'(out_valid), 0);
      check(out_mag == '0, "R11 mid-stream data", int'(out_mag), 0);
      rst = 1'b0;
      in_valid = 1'b0;
      clear_hist();
      step(1, -100, 20, 3, 6);
      repeat (5) step(0, 0, 0, 0, 10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule